// File: doc/BRIEF.md
# Legacy I/O Controller Configuration Port

This block implements the plug-and-play configuration interface of a legacy multi-function I/O controller as seen from an 8-bit host I/O bus. It powers up in run mode, where its configuration ports give no answer. The host moves it into configuration mode by writing a fixed four-byte unlock key to address 0x2E. The last key byte also decides where the index/data port pair answers: at 0x2E/0x2F or at 0x4E/0x4F.

In configuration mode the host writes a register number to the index port. It then reads or writes that register through the data port, which sits one address above the index port. Registers below 0x30 are global. Registers from 0x30 up belong to the bank of the logical device named by the device-number register. Each implemented device bank drives one enable output from its activate bit. A global register drives a clock-select output. A configuration-select register can restrict writes to one of two controllers sharing the bus, chosen by a strap input. Writing the exit bit of the write-only configure-control register returns the block to run mode.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is in run mode, every bit of `dev_enable` is 0, `clk_sel_24m` is 0, and the device-number register (0x07) holds 0.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 to 0x2E enters configuration mode with the index port at 0x2E and the data port at 0x2F. Ending the key with 0xAA instead places the index port at 0x4E and the data port at 0x4F, and the 0x2E/0x2F pair then reads 0xFF.
- R3: The key detector counts only run-mode writes to 0x2E. A byte that does not match the expected key byte returns the detector to its first step, except a mismatching 0x87, which counts as the first key byte.
- R4: In run mode, reads of the port addresses return 0xFF and writes to them change no register or output. `io_rdata` is also 0xFF for any access to an address other than the active index/data pair.
- R5: In configuration mode a write to the index port selects a register, and reading the index port returns the selected register number. A data-port access then reads or writes the selected register.
- R6: Register 0x07 holds the logical device number. Indexes 0x30 and up reach the bank of that device. Bit 0 of bank register 0x30 drives `dev_enable[n]` for device n. Each bank holds BANK_REGS bytes starting at 0x30, and each byte reads back what was written.
- R7: Register 0x02 is write-only and reads 0x00. A write to it with bit 1 set returns the block to run mode. A write with bit 1 clear leaves it in configuration mode.
- R8: Bit 0 of register 0x24 drives `clk_sel_24m`. Register 0x23 (suspend) is a read/write byte.
- R9: Until register 0x22 has been written, every data-port write takes effect. After that, data-port writes to any register other than 0x22 take effect only when bit 7 of 0x22 equals `strap_id`. Reads are unaffected.
- R10: With a device number of NUM_LDN or more, bank reads return 0xFF and bank writes are discarded. Bank offsets at or beyond BANK_REGS read 0xFF, and so do global registers other than 0x02, 0x07, 0x22, 0x23 and 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| strap_id | input | 1 | Jumper value identifying this controller |
| dev_enable | output | NUM_LDN | Activate bit of each logical device |
| clk_sel_24m | output | 1 | Clock-select bit |

## Verification
The embedded assertions watch four rules on every cycle. Configuration mode can only begin on a write to 0x2E. It can only end on a write with bit 1 set. The enable and clock-select outputs stay frozen in run mode and while the controller is deselected. Device and register storage hold still when no write is aimed at them. Only the bench's scenarios can show the rest: that the key is recognised with its restart on 0x87, that the 0xAA key moves the ports, that data lands in the right bank, the 0xFF and 0x00 read values, and that register 0x22 selects one of the two chips.

// File: rtl/sio_cfg_pkg.sv
// Package: constants shared by the configuration-port blocks.
// Assumes an 8-bit data path; address constants are widened at use.
package sio_cfg_pkg;
    localparam logic [7:0] KEY_B0      = 8'h87;
    localparam logic [7:0] KEY_B1      = 8'h01;
    localparam logic [7:0] KEY_B2      = 8'h55;
    localparam logic [7:0] KEY_LO_END  = 8'h55;
    localparam logic [7:0] KEY_HI_END  = 8'hAA;
    localparam logic [7:0] PORT_LO     = 8'h2E;
    localparam logic [7:0] PORT_HI     = 8'h4E;
    localparam logic [7:0] IDX_CCTRL   = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_CHIPSEL = 8'h22;
    localparam logic [7:0] IDX_SUSP    = 8'h23;
    localparam logic [7:0] IDX_CLKSEL  = 8'h24;
    localparam logic [7:0] IDX_BANK0   = 8'h30;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_GOT0 = 2'd1,
        KS_GOT1 = 2'd2,
        KS_GOT2 = 2'd3
    } key_state_t;
endpackage

// File: rtl/sio_key_detect.sv
// Unlock-key detector: follows the four-byte key on watched writes.
// Assumes key_wr is already qualified (run mode, address 0x2E).
module sio_key_detect
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       enter,
    output logic       enter_hi
);
    key_state_t state_q, state_d;
    logic       restart_one;

    // Purpose: a mismatching 0x87 counts as the first key byte.
    assign restart_one = (key_byte == KEY_B0);

    // Purpose: compute the next key step and the entry pulse.
    always_comb begin
        state_d  = state_q;
        enter    = 1'b0;
        enter_hi = 1'b0;
        if (key_wr) begin
            unique case (state_q)
                KS_IDLE: state_d = restart_one ? KS_GOT0 : KS_IDLE;
                KS_GOT0: state_d = (key_byte == KEY_B1) ? KS_GOT1
                                 : (restart_one ? KS_GOT0 : KS_IDLE);
                KS_GOT1: state_d = (key_byte == KEY_B2) ? KS_GOT2
                                 : (restart_one ? KS_GOT0 : KS_IDLE);
                KS_GOT2: begin
                    if (key_byte == KEY_LO_END || key_byte == KEY_HI_END) begin
                        enter    = 1'b1;
                        enter_hi = (key_byte == KEY_HI_END);
                        state_d  = KS_IDLE;
                    end else begin
                        state_d = restart_one ? KS_GOT0 : KS_IDLE;
                    end
                end
                default: state_d = KS_IDLE;
            endcase
        end
    end

    // Purpose: hold the key step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // R3
    key_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(state_q));
endmodule

// File: rtl/sio_global_regs.sv
// Global configuration registers: device number, chip select,
// suspend, clock select, and the write-only configure control.
// Assumes wr_en is already gated by mode and chip selection.
module sio_global_regs
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn,
    output logic [7:0] chipsel,
    output logic       chipsel_seen,
    output logic       clksel,
    output logic       exit_req,
    output logic [7:0] rdata
);
    logic [7:0] ldn_q, chipsel_q, susp_q, clksel_q;
    logic       seen_q;

    // Purpose: store writes to the global registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q     <= 8'h00;
            chipsel_q <= 8'h00;
            susp_q    <= 8'h00;
            clksel_q  <= 8'h00;
            seen_q    <= 1'b0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_LDN:     ldn_q <= wdata;
                IDX_CHIPSEL: begin
                    chipsel_q <= wdata;
                    seen_q    <= 1'b1;
                end
                IDX_SUSP:    susp_q <= wdata;
                IDX_CLKSEL:  clksel_q <= wdata;
                default:     ;
            endcase
        end
    end

    // Purpose: decode the read value of the selected global register.
    always_comb begin
        unique case (idx)
            IDX_CCTRL:   rdata = 8'h00;
            IDX_LDN:     rdata = ldn_q;
            IDX_CHIPSEL: rdata = chipsel_q;
            IDX_SUSP:    rdata = susp_q;
            IDX_CLKSEL:  rdata = clksel_q;
            default:     rdata = 8'hFF;
        endcase
    end

    assign exit_req     = wr_en && (idx == IDX_CCTRL) && wdata[1];
    assign ldn          = ldn_q;
    assign chipsel      = chipsel_q;
    assign chipsel_seen = seen_q;
    assign clksel       = clksel_q[0];

    // R6
    ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ldn_q));
endmodule

// File: rtl/sio_ldn_bank.sv
// One logical-device register bank of BANK_REGS bytes from index 0x30.
// Byte 0 bit 0 is the activate bit. Assumes wr_en is fully qualified.
module sio_ldn_bank #(
    parameter int BANK_REGS = 4,
    localparam int OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             active
);
    logic [7:0] regs_q [BANK_REGS];

    // Purpose: store bank writes at the addressed offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_REGS; i++) regs_q[i] <= 8'h00;
        end else if (wr_en) begin
            regs_q[off] <= wdata;
        end
    end

    // Purpose: read the addressed byte, 0xFF beyond the bank.
    always_comb begin
        rdata = 8'hFF;
        for (int i = 0; i < BANK_REGS; i++)
            if (off == OFF_W'(i)) rdata = regs_q[i];
    end

    assign active = regs_q[0][0];

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(active));
endmodule

// File: rtl/sio_cfg_port.sv
// Top: configuration-port controller. Tracks run/configuration mode,
// decodes the index/data pair, gates writes by chip select, and
// routes bank accesses to the selected logical device.
// Assumes single-cycle io_wr pulses; io_rdata is combinational.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_LDN   = 4,
    parameter int BANK_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              strap_id,
    output logic [NUM_LDN-1:0] dev_enable,
    output logic              clk_sel_24m
);
    localparam int OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(PORT_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(PORT_HI);

    logic              cfg_mode_q, hi_q;
    logic [7:0]        index_q;
    logic              key_wr, enter, enter_hi, exit_req;
    logic [ADDR_W-1:0] idx_port, dat_port;
    logic              hit_idx, hit_dat, data_wr, chip_ok;
    logic              glob_wr, is_bank, ldn_ok, off_ok;
    logic [7:0]        off_full, ldn, chipsel, glob_rd, bank_sel_rd, reg_rd;
    logic              chipsel_seen;
    logic [7:0]        bank_rd [NUM_LDN];

    assign key_wr   = !cfg_mode_q && io_wr && (io_addr == A_LO);
    assign idx_port = hi_q ? A_HI : A_LO;
    assign dat_port = idx_port + ADDR_W'(1);
    assign hit_idx  = cfg_mode_q && (io_addr == idx_port);
    assign hit_dat  = cfg_mode_q && (io_addr == dat_port);
    assign data_wr  = hit_dat && io_wr;
    assign chip_ok  = !chipsel_seen || (chipsel[7] == strap_id);
    assign is_bank  = (index_q >= IDX_BANK0);
    assign off_full = index_q - IDX_BANK0;
    assign off_ok   = (32'(off_full) < BANK_REGS);
    assign ldn_ok   = (32'(ldn) < NUM_LDN);
    assign glob_wr  = data_wr && !is_bank && (chip_ok || index_q == IDX_CHIPSEL);

    sio_key_detect u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (io_wdata),
        .enter    (enter),
        .enter_hi (enter_hi)
    );

    sio_global_regs u_glob (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (glob_wr),
        .idx          (index_q),
        .wdata        (io_wdata),
        .ldn          (ldn),
        .chipsel      (chipsel),
        .chipsel_seen (chipsel_seen),
        .clksel       (clk_sel_24m),
        .exit_req     (exit_req),
        .rdata        (glob_rd)
    );

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        logic bank_wr;
        assign bank_wr = data_wr && chip_ok && is_bank && off_ok && (ldn == 8'(g));
        sio_ldn_bank #(.BANK_REGS(BANK_REGS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bank_wr),
            .off    (off_full[OFF_W-1:0]),
            .wdata  (io_wdata),
            .rdata  (bank_rd[g]),
            .active (dev_enable[g])
        );
    end

    // Purpose: track run/configuration mode and the port-pair choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode_q <= 1'b0;
            hi_q       <= 1'b0;
        end else if (enter) begin
            cfg_mode_q <= 1'b1;
            hi_q       <= enter_hi;
        end else if (exit_req) begin
            cfg_mode_q <= 1'b0;
        end
    end

    // Purpose: capture index-port writes in configuration mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= 8'h00;
        else if (hit_idx && io_wr) index_q <= io_wdata;
    end

    // Purpose: pick the byte of the selected device bank.
    always_comb begin
        bank_sel_rd = 8'hFF;
        for (int i = 0; i < NUM_LDN; i++)
            if (ldn == 8'(i)) bank_sel_rd = bank_rd[i];
    end

    // Purpose: form the host read value.
    always_comb begin
        reg_rd = is_bank ? ((ldn_ok && off_ok) ? bank_sel_rd : 8'hFF) : glob_rd;
        if (!io_rd)       io_rdata = 8'hFF;
        else if (hit_idx) io_rdata = index_q;
        else if (hit_dat) io_rdata = reg_rd;
        else              io_rdata = 8'hFF;
    end

    // R2
    enter_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode_q) |-> ($past(io_wr) && $past(io_addr) == A_LO));
    // R7
    exit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_mode_q) |-> ($past(io_wr) && $past(io_wdata[1])));
    // R4
    run_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode_q |=> ($stable(dev_enable) && $stable(clk_sel_24m)));
    // R9
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chipsel_seen && chipsel[7] != strap_id && index_q != IDX_CHIPSEL)
            |=> ($stable(dev_enable) && $stable(clk_sel_24m)));
endmodule

// File: tb/tb_sio_cfg_port.sv
// Scoreboard bench: driver tasks queue expected items, a monitor
// pops and compares them at a sample point between clock edges.
module tb_sio_cfg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        strap_id = 1'b0;
    logic [3:0]  dev_enable;
    logic        clk_sel_24m;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int         kind;   // 0 read data, 1 enables, 2 clock select
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];
    event  sample_ev;

    always #4 clk = ~clk;

    sio_cfg_port dut (
        .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
        .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
        .strap_id (strap_id), .dev_enable (dev_enable),
        .clk_sel_24m (clk_sel_24m)
    );

    // Monitor: pop one expected item per sample event and compare.
    always @(sample_ev) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
            0:       act = io_rdata;
            1:       act = {4'h0, dev_enable};
            default: act = {7'h0, clk_sel_24m};
        endcase
        checks++;
        if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        sb_q.push_back('{0, e, tag});
        #2 -> sample_ev;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic out_chk(input int k, input logic [7:0] e, input string tag);
        @(negedge clk);
        sb_q.push_back('{k, e, tag});
        #2 -> sample_ev;
    endtask

    task automatic cfg_w(input logic [15:0] b, input logic [7:0] idx, input logic [7:0] d);
        wr(b, idx);
        wr(b + 16'd1, d);
    endtask

    task automatic cfg_r(input logic [15:0] b, input logic [7:0] idx, input logic [7:0] e,
                         input string tag);
        wr(b, idx);
        rd_chk(b + 16'd1, e, tag);
    endtask

    task automatic key(input logic [15:0] a, input logic [7:0] last);
        wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, last);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        out_chk(1, 8'h00, "R1 enables after reset");
        out_chk(2, 8'h00, "R1 clock select after reset");
        rd_chk(16'h002F, 8'hFF, "R1 run mode after reset");
        // R4 run-mode writes have no effect
        wr(16'h002F, 8'h01);
        out_chk(1, 8'h00, "R4 run-mode data write ignored");
        rd_chk(16'h002E, 8'hFF, "R4 run-mode index read");
        // R3 broken key does not unlock
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55);
        wr(16'h002E, 8'h00); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
        wr(16'h002E, 8'h07);
        rd_chk(16'h002F, 8'hFF, "R3 mismatch restarts key");
        // R3 key written to another address is not watched
        key(16'h004E, 8'h55);
        wr(16'h002E, 8'h07);
        rd_chk(16'h002F, 8'hFF, "R3 key at 0x4E ignored");
        // R3 restart on 0x87 inside the key
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
        key(16'h002E, 8'h55);
        cfg_r(16'h002E, 8'h07, 8'h00, "R3 0x87 restart unlocks, R1 ldn 0");
        // R5 index readback and foreign address
        wr(16'h002E, 8'h24);
        rd_chk(16'h002E, 8'h24, "R5 index readback");
        rd_chk(16'h004F, 8'hFF, "R4 foreign address reads FF");
        // R6 device banks
        cfg_w(16'h002E, 8'h07, 8'h01);
        cfg_w(16'h002E, 8'h30, 8'h01);
        cfg_w(16'h002E, 8'h31, 8'hA5);
        out_chk(1, 8'h02, "R6 device 1 enabled");
        cfg_r(16'h002E, 8'h31, 8'hA5, "R6 bank byte readback");
        cfg_r(16'h002E, 8'h30, 8'h01, "R6 activate readback");
        cfg_w(16'h002E, 8'h07, 8'h02);
        cfg_r(16'h002E, 8'h30, 8'h00, "R6 banks are separate");
        cfg_w(16'h002E, 8'h30, 8'h01);
        out_chk(1, 8'h06, "R6 device 2 enabled");
        // R10 missing device and offsets
        cfg_w(16'h002E, 8'h07, 8'h09);
        cfg_r(16'h002E, 8'h30, 8'hFF, "R10 missing device reads FF");
        cfg_w(16'h002E, 8'h30, 8'h00);
        out_chk(1, 8'h06, "R10 missing device write discarded");
        cfg_w(16'h002E, 8'h07, 8'h01);
        cfg_r(16'h002E, 8'h35, 8'hFF, "R10 offset beyond bank");
        cfg_r(16'h002E, 8'h10, 8'hFF, "R10 unknown global");
        // R8 clock select and suspend
        cfg_w(16'h002E, 8'h24, 8'h01);
        out_chk(2, 8'h01, "R8 clock select set");
        cfg_r(16'h002E, 8'h24, 8'h01, "R8 clock select readback");
        cfg_w(16'h002E, 8'h23, 8'h01);
        cfg_r(16'h002E, 8'h23, 8'h01, "R8 suspend readback");
        // R9 chip selection
        cfg_w(16'h002E, 8'h22, 8'h80);
        cfg_w(16'h002E, 8'h24, 8'h00);
        out_chk(2, 8'h01, "R9 deselected write blocked");
        cfg_r(16'h002E, 8'h22, 8'h80, "R9 reads still served");
        cfg_w(16'h002E, 8'h22, 8'h00);
        cfg_w(16'h002E, 8'h24, 8'h00);
        out_chk(2, 8'h00, "R9 selected write applies");
        // R7 configure control
        cfg_r(16'h002E, 8'h02, 8'h00, "R7 write-only reads 00");
        cfg_w(16'h002E, 8'h02, 8'h01);
        cfg_r(16'h002E, 8'h07, 8'h01, "R7 bit1 clear stays in config");
        cfg_w(16'h002E, 8'h02, 8'h02);
        rd_chk(16'h002F, 8'hFF, "R7 exit to run mode");
        out_chk(1, 8'h06, "R7 enables kept after exit");
        // R2 alternate port pair
        key(16'h002E, 8'hAA);
        wr(16'h002E, 8'h07);
        rd_chk(16'h002F, 8'hFF, "R2 low pair silent in high mode");
        cfg_r(16'h004E, 8'h07, 8'h01, "R2 high pair answers");
        cfg_w(16'h004E, 8'h30, 8'h00);
        out_chk(1, 8'h04, "R2 write via high pair");
        cfg_w(16'h004E, 8'h02, 8'h02);
        rd_chk(16'h004F, 8'hFF, "R2 high pair exit");
        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end
endmodule